// File: doc/BRIEF.md
# Legacy Peripheral Clock-Locked Access Bridge

This block couples a fast processor bus, whose cycles are normally ended by an acknowledge, to older peripherals. Those peripherals accept an access only inside a fixed window that is locked to a slow enable clock. The bridge derives that enable clock from the system clock with a free-running divide-by-ten phase counter. The enable is low for six system clocks and high for four.

When the address decode of a slow peripheral drives the active-low peripheral request, the bridge resynchronises that request. It then waits for the start of the next enable period and drives its active-low access grant for exactly one full period. The transfer is taken as complete on the falling edge of the enable, and the bridge signals this with a one-clock done pulse to the bus cycle logic. The grant is held until the processor lifts its address strobe. No new slow access can begin until the request line has been observed inactive again.

Top module: `legacy_periph_bridge`

## Requirements
- R1: While reset is active and in the first cycle after it, `slow_en` is 0, `grant_n` is 1 and `xfer_done` is 0; the phase counter restarts at phase 0.
- R2: The phase counter steps 0,1,…,9,0 on every clock; `slow_en` is 1 exactly in phases 6 to 9, so each period is 6 clocks low and 4 clocks high.
- R3: `periph_req_n` (active low) passes through a two-flop synchronizer; a slow access is requested only while the synchronized request is active and `strobe_n` is 0.
- R4: `grant_n` goes to 0 at the first phase-0 edge that comes at least three rising clock edges after `periph_req_n` was driven low; if that edge is the third, the grant starts there.
- R5: `grant_n` stays 0 for the whole ten-clock period. `xfer_done` is 1 for exactly one clock, in the first cycle of the following period, ten edges after the grant edge (the falling edge of `slow_en`).
- R6: After the done pulse, `grant_n` stays 0 until `strobe_n` is sampled 1; it returns to 1 on that same edge.
- R7: After an access ends or is abandoned, no new grant is given until the synchronized request has been inactive for at least one cycle, even if `strobe_n` is asserted again.
- R8: If `strobe_n` returns to 1 while the bridge waits for phase 0, the access is abandoned and `grant_n` is never driven low for it.
- R9: Bus activity never disturbs the phase counter: `slow_en` keeps its R2 pattern through every access.
- R10: A low `periph_req_n` with `strobe_n` at 1 starts no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Processor address strobe, active low |
| periph_req_n | input | 1 | Slow-peripheral request from address decode, active low, asynchronous |
| slow_en | output | 1 | Enable clock, system clock divided by ten (6 low, 4 high) |
| grant_n | output | 1 | Clock-locked access grant, active low |
| xfer_done | output | 1 | One-cycle pulse marking completion of the slow transfer |

## Verification
Request detection and the period boundary can fall in the same cycle: the synchronized request becomes visible exactly in phase 9. In that case the bridge must grant at once rather than wait a full extra period. The table walk provokes this by dropping the request when the phase is 7, and also at the neighbouring phases 6 and 8. The expected grant edge is fixed for each phase, and the bench judges it by requiring `grant_n` high one edge before that edge and low on it. A second coincidence, strobe release during the alignment wait, is driven explicitly and must leave the grant unasserted.

// File: rtl/legacy_bridge_pkg.sv
package legacy_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_OPEN,
    ST_HOLD,
    ST_REARM
  } bridge_state_t;

  // Next value of a free-running modulo-div phase counter.
  function automatic int unsigned phase_step(input int unsigned p, input int unsigned div);
    return (p + 1 >= div) ? 0 : p + 1;
  endfunction

  // Level of the enable clock for a given phase.
  function automatic logic enable_level(input int unsigned p, input int unsigned low_len);
    return (p >= low_len);
  endfunction

endpackage

// File: rtl/slow_phase_gen.sv
module slow_phase_gen
  import legacy_bridge_pkg::*;
#(
  parameter int unsigned DIV     = 10,
  parameter int unsigned LOW_LEN = 6,
  localparam int unsigned PW     = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_en,
  output logic last_tick,
  output logic first_tick
);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= PW'(phase_step(int'(phase_q), DIV));
  end

  assign slow_en    = enable_level(int'(phase_q), LOW_LEN);
  assign last_tick  = (int'(phase_q) == DIV - 1);
  assign first_tick = (phase_q == '0);

  // R2: the enable drops only when the period wraps to phase 0
  a_r2_fall_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_en) |-> first_tick);

  // R2: the enable rises only at the low/high boundary
  a_r2_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_en) |-> (int'(phase_q) == LOW_LEN));

  // R9: the counter leaves the last phase only towards phase 0
  a_r9_wrap_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> first_tick);

endmodule

// File: rtl/req_synchronizer.sv
module req_synchronizer #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_seen
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b1;
          else        stage_q[0] <= req_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign req_seen = ~stage_q[STAGES-1];

endmodule

// File: rtl/access_sequencer.sv
module access_sequencer
  import legacy_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  input  logic strobe_n,
  input  logic last_tick,
  input  logic first_tick,
  input  logic slow_en,
  output logic grant_n,
  output logic xfer_done
);

  bridge_state_t state_q, state_d;
  logic          grant_d;
  logic          done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_seen && !strobe_n) state_d = last_tick ? ST_OPEN : ST_ALIGN;
      ST_ALIGN: if (strobe_n)              state_d = ST_REARM;
                else if (last_tick)        state_d = ST_OPEN;
      ST_OPEN:  if (last_tick)             state_d = ST_HOLD;
      ST_HOLD:  if (strobe_n)              state_d = ST_REARM;
      ST_REARM: if (!req_seen)             state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  assign grant_d = (state_d == ST_OPEN) || (state_d == ST_HOLD);
  assign done_d  = (state_q == ST_OPEN) && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      grant_n   <= 1'b1;
      xfer_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      grant_n   <= ~grant_d;
      xfer_done <= done_d;
    end
  end

  // R4: a grant always opens on the first phase of a period
  a_r4_grant_at_period: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> first_tick);

  // R3: a grant needs a synchronized request in the cycle before
  a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(req_seen));

  // R5: completion coincides with the enable falling while the grant is held
  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($fell(slow_en) && !grant_n));

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R6: the grant is withdrawn only after the strobe was seen released
  a_r6_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_n) |-> $past(strobe_n));

  // R7: while waiting for the request to go away no grant may open
  a_r7_rearm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REARM) |=> grant_n);

endmodule

// File: rtl/legacy_periph_bridge.sv
module legacy_periph_bridge #(
  parameter int unsigned DIV         = 10,
  parameter int unsigned LOW_LEN     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic periph_req_n,
  output logic slow_en,
  output logic grant_n,
  output logic xfer_done
);

  logic req_seen;
  logic last_tick;
  logic first_tick;

  slow_phase_gen #(
    .DIV     (DIV),
    .LOW_LEN (LOW_LEN)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_en    (slow_en),
    .last_tick  (last_tick),
    .first_tick (first_tick)
  );

  req_synchronizer #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_async (periph_req_n),
    .req_seen    (req_seen)
  );

  access_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_seen   (req_seen),
    .strobe_n   (strobe_n),
    .last_tick  (last_tick),
    .first_tick (first_tick),
    .slow_en    (slow_en),
    .grant_n    (grant_n),
    .xfer_done  (xfer_done)
  );

  // R1: the grant and done are idle in the first cycle out of reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (grant_n && !xfer_done));

endmodule

// File: tb/legacy_periph_bridge_tb.sv
module legacy_periph_bridge_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_n = 1'b1;
  logic periph_req_n = 1'b1;
  logic slow_en, grant_n, xfer_done;

  int checks = 0;
  int errors = 0;
  int mcnt = 0;
  bit mon_en = 1'b0;
  bit over = 1'b0;

  always #10 clk = ~clk;

  legacy_periph_bridge u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_n     (strobe_n),
    .periph_req_n (periph_req_n),
    .slow_en      (slow_en),
    .grant_n      (grant_n),
    .xfer_done    (xfer_done)
  );

  // Phase model from the requirement: 0..9, restarting at reset
  always @(posedge clk) begin
    if (!rst_n) mcnt <= 0;
    else        mcnt <= (mcnt == 9) ? 0 : mcnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // R2 / R9: enable pattern checked on every cycle, also during accesses
  always @(negedge clk) begin
    if (mon_en) chk("R2/R9 enable level", int'(slow_en), (mcnt >= 6) ? 1 : 0);
  end

  task automatic wait_phase(input int p);
    do @(negedge clk); while (mcnt != p);
  endtask

  // Request phase and the edge count (from the drive) at which the grant opens
  localparam int NV = 8;
  localparam int VPH [NV] = '{0, 1, 3, 5, 6, 7, 8, 9};
  localparam int VN  [NV] = '{10, 9, 7, 5, 4, 3, 12, 11};

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      over = 1'b1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 enable in reset", int'(slow_en), 0);
    chk("R1 grant in reset", int'(grant_n), 1);
    chk("R1 done in reset", int'(xfer_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant after reset", int'(grant_n), 1);
    chk("R1 phase restarted", mcnt, 1);
    mon_en = 1'b1;
    repeat (12) @(negedge clk);

    // R4/R5/R6 table walk, including R4 coincidence at phase 7
    for (int i = 0; i < NV; i++) begin
      wait_phase(VPH[i]);
      periph_req_n = 1'b0;
      strobe_n = 1'b0;
      for (int k = 1; k <= VN[i] + 11; k++) begin
        @(negedge clk);
        if (k == VN[i] - 1) chk("R4 grant not early", int'(grant_n), 1);
        if (k == VN[i])     chk("R4 grant on phase 0", int'(grant_n), 0);
        if (k == VN[i] + 9) chk("R5 no early done", int'(xfer_done), 0);
        if (k == VN[i] + 10) begin
          chk("R5 done pulse", int'(xfer_done), 1);
          chk("R5 grant during done", int'(grant_n), 0);
        end
        if (k == VN[i] + 11) begin
          chk("R5 done single", int'(xfer_done), 0);
          chk("R6 grant held with strobe", int'(grant_n), 0);
        end
      end
      strobe_n = 1'b1;
      @(negedge clk);
      chk("R6 grant released", int'(grant_n), 1);
      periph_req_n = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R7: request kept low after an access; a new strobe must not grant
    periph_req_n = 1'b0;
    strobe_n = 1'b0;
    repeat (25) @(negedge clk);
    strobe_n = 1'b1;
    repeat (2) @(negedge clk);
    strobe_n = 1'b0;
    begin
      int low = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (!grant_n) low++;
      end
      chk("R7 no grant without rearm", low, 0);
    end
    strobe_n = 1'b1;
    periph_req_n = 1'b1;
    repeat (4) @(negedge clk);
    periph_req_n = 1'b0;
    strobe_n = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        if (!grant_n) seen = 1;
      end
      chk("R7 grant after rearm", seen, 1);
    end
    repeat (12) @(negedge clk);
    strobe_n = 1'b1;
    periph_req_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: strobe released while aligning
    wait_phase(8);
    periph_req_n = 1'b0;
    strobe_n = 1'b0;
    repeat (5) @(negedge clk);
    strobe_n = 1'b1;
    begin
      int low = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!grant_n) low++;
      end
      chk("R8 abandoned access", low, 0);
    end
    strobe_n = 1'b0;
    begin
      int low = 0;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (!grant_n) low++;
      end
      chk("R7 abandoned needs rearm", low, 0);
    end
    strobe_n = 1'b1;
    periph_req_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: request without strobe
    periph_req_n = 1'b0;
    begin
      int low = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!grant_n) low++;
      end
      chk("R10 no access without strobe", low, 0);
    end
    strobe_n = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        if (!grant_n) seen = 1;
      end
      chk("R3 strobe completes request", seen, 1);
    end
    repeat (12) @(negedge clk);
    strobe_n = 1'b1;
    periph_req_n = 1'b1;
    repeat (4) @(negedge clk);

    if (!over) begin
      over = 1'b1;
      finish_run();
    end
  end

endmodule